// File: doc/BRIEF.md
# Victim Cache Beside a Direct-Mapped Cache

This block is a read-only direct-mapped line cache with a small fully-associative victim buffer on its refill path. The processor presents one line address at a time. If the direct-mapped set holds that line, the line is returned on the next cycle. If the set misses, every victim entry is compared against the address at once. On a victim hit, the requested line and the line currently in the set trade places, which costs one extra cycle. On a victim miss, the line is read from the next memory level, written into the set, and the line it pushes out is kept in the victim buffer.

The requested line is never put into the victim buffer. Only lines pushed out of the direct-mapped array go there. The buffer therefore catches lines that keep evicting each other from the same set. The next-level port issues a one-cycle read pulse and accepts the returned line after any number of cycles. Write-back and coherence are not handled.

Top module: `victim_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_rd_valid are 0, and every line and victim entry is invalid, so the first access to any line address is served from the next memory level.
- R2: A request accepted while the direct-mapped set holds its line gives resp_valid in the next cycle with resp_src = 2'd0 and that line's data, and no next-level read.
- R3: The victim buffer is searched only when the direct-mapped set misses. A victim hit gives resp_valid two cycles after acceptance with resp_src = 2'd1 and the line's data, and no next-level read.
- R4: On a victim hit, the requested line moves into its direct-mapped set. A valid line displaced from that set takes the victim entry that was freed.
- R5: When both structures miss, mem_rd_valid pulses for one cycle in the cycle after acceptance, with mem_rd_addr equal to the requested line address. The response comes in the cycle after mem_rsp_valid, carrying mem_rsp_data with resp_src = 2'd2.
- R6: On a refill from memory, a valid line displaced from the set is written into the victim buffer. The requested line is not written there.
- R7: A refill into an invalid direct-mapped set leaves the victim buffer unchanged.
- R8: A displaced line goes into the lowest-numbered empty victim entry if one exists. Otherwise it goes into the entry written least recently, where both a swap and a refill count as writes.
- R9: No line address matches more than one victim entry.
- R10: The next memory level may take any number of cycles from one upward to return a line.
- R11: req_ready is 0 from the cycle after a request is accepted that misses the direct-mapped set, until its response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_addr | input | ADDR_W | Requested line address |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response present for one cycle |
| resp_data | output | DATA_W | Line data returned |
| resp_src | output | 2 | Where the line was found: 0 direct, 1 victim, 2 memory |
| mem_rd_valid | output | 1 | One-cycle read pulse to the next level |
| mem_rd_addr | output | ADDR_W | Line address of the next-level read |
| mem_rsp_valid | input | 1 | Next level returns the line |
| mem_rsp_data | input | DATA_W | Line data from the next level |

## Verification
The case hardest to reach from the ports is a full victim buffer where the entry to replace differs from the one in fill order, so that the least-recently-written choice is actually tested. The bench reaches it by cycling more conflicting tags than there are victim entries through each set, forward and then in reverse, and then running a long interleaved address sequence over a small configuration. A reference model of both structures, based on write order, predicts on every access whether the line comes from the direct array, the victim buffer or memory. Memory latency is varied on every miss.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_VICTIM = 2'd1,
    SRC_MEMORY = 2'd2
  } vc_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SWAP = 2'd1,
    ST_WAIT = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vc_dm_store.sv
module vc_dm_store #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_line,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag;

  assign lk_idx   = lk_addr[IDX_W-1:0];
  assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
  assign wr_idx   = wr_addr[IDX_W-1:0];
  assign lk_valid = vld_q[lk_idx];
  assign lk_hit   = lk_valid && (tag_q[lk_idx] == lk_tag);
  assign lk_line  = {tag_q[lk_idx], lk_idx};
  assign lk_data  = dat_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_addr[ADDR_W-1:IDX_W];
      dat_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  localparam int WAY_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               lk_hit,
  output logic [ENTRIES-1:0] lk_hit_vec,
  output logic [WAY_W-1:0]   lk_way,
  output logic [DATA_W-1:0]  lk_data,
  output logic [WAY_W-1:0]   repl_way,
  input  logic               wr_en,
  input  logic [WAY_W-1:0]   wr_way,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data
);
  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  adr_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [WAY_W-1:0]   age_q [ENTRIES];
  logic [WAY_W-1:0]   age_d [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    assign lk_hit_vec[gi] = vld_q[gi] && (adr_q[gi] == lk_addr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[gi] <= 1'b0;
        age_q[gi] <= WAY_W'(gi);
      end else if (wr_en) begin
        age_q[gi] <= age_d[gi];
        if (wr_way == WAY_W'(gi)) vld_q[gi] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(gi))) begin
        adr_q[gi] <= wr_addr;
        dat_q[gi] <= wr_data;
      end
    end
  end

  assign lk_hit = |lk_hit_vec;

  always_comb begin
    lk_way  = '0;
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) begin
        lk_way  = WAY_W'(i);
        lk_data = dat_q[i];
      end
    end
  end

  // Lowest empty entry first, otherwise the oldest written one.
  always_comb begin
    logic found;
    found    = 1'b0;
    repl_way = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !vld_q[i]) begin
        found    = 1'b1;
        repl_way = WAY_W'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == WAY_W'(ENTRIES - 1)) repl_way = WAY_W'(i);
      end
    end
  end

  // Ages stay a permutation: the written entry becomes 0, younger ones age by one.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (WAY_W'(i) == wr_way)              age_d[i] = '0;
      else if (age_q[i] < age_q[wr_way])    age_d[i] = age_q[i] + 1'b1;
      else                                   age_d[i] = age_q[i];
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 3,
  parameter int DATA_W     = 32,
  parameter int VC_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_src,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  import vc_pkg::*;
  localparam int WAY_W = (VC_ENTRIES > 1) ? $clog2(VC_ENTRIES) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  vc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] cur_q;
  logic              rv_q, rv_d, mrv_q, mrv_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  vc_src_e           rsrc_q, rsrc_d;
  logic              accept;

  logic [ADDR_W-1:0] look_addr;
  logic              dm_hit, dm_valid, dm_wr;
  logic [ADDR_W-1:0] dm_line;
  logic [DATA_W-1:0] dm_data, dm_wdata;

  logic                  vb_hit, vb_wr, vb_wvalid;
  logic [VC_ENTRIES-1:0] vb_hit_vec;
  logic [WAY_W-1:0]      vb_way, vb_repl, vb_wway;
  logic [DATA_W-1:0]     vb_data;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign look_addr = (state_q == ST_IDLE) ? req_addr : cur_q;

  vc_dm_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dm (
    .clk(clk), .rst_n(rst_i_n), .lk_addr(look_addr), .lk_hit(dm_hit),
    .lk_valid(dm_valid), .lk_line(dm_line), .lk_data(dm_data),
    .wr_en(dm_wr), .wr_addr(cur_q), .wr_data(dm_wdata)
  );

  vc_victim_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(VC_ENTRIES)) u_vb (
    .clk(clk), .rst_n(rst_i_n), .lk_addr(look_addr), .lk_hit(vb_hit),
    .lk_hit_vec(vb_hit_vec), .lk_way(vb_way), .lk_data(vb_data),
    .repl_way(vb_repl), .wr_en(vb_wr), .wr_way(vb_wway), .wr_valid(vb_wvalid),
    .wr_addr(dm_line), .wr_data(dm_data)
  );

  always_comb begin
    state_d   = state_q;
    rv_d      = 1'b0;
    mrv_d     = 1'b0;
    rdata_d   = rdata_q;
    rsrc_d    = rsrc_q;
    dm_wr     = 1'b0;
    dm_wdata  = mem_rsp_data;
    vb_wr     = 1'b0;
    vb_wway   = vb_repl;
    vb_wvalid = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dm_hit) begin
            rv_d    = 1'b1;
            rdata_d = dm_data;
            rsrc_d  = SRC_DIRECT;
          end else if (vb_hit) begin
            state_d = ST_SWAP;
          end else begin
            state_d = ST_WAIT;
            mrv_d   = 1'b1;
          end
        end
      end
      ST_SWAP: begin
        dm_wr     = 1'b1;
        dm_wdata  = vb_data;
        vb_wr     = 1'b1;
        vb_wway   = vb_way;
        vb_wvalid = dm_valid;
        rv_d      = 1'b1;
        rdata_d   = vb_data;
        rsrc_d    = SRC_VICTIM;
        state_d   = ST_IDLE;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          dm_wr   = 1'b1;
          vb_wr   = dm_valid;
          rv_d    = 1'b1;
          rdata_d = mem_rsp_data;
          rsrc_d  = SRC_MEMORY;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      rv_q    <= 1'b0;
      mrv_q   <= 1'b0;
      rsrc_q  <= SRC_DIRECT;
    end else begin
      state_q <= state_d;
      rv_q    <= rv_d;
      mrv_q   <= mrv_d;
      if (rv_d) rsrc_q <= rsrc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) cur_q   <= req_addr;
    if (rv_d)   rdata_q <= rdata_d;
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign resp_valid   = rv_q;
  assign resp_data    = rdata_q;
  assign resp_src     = rsrc_q;
  assign mem_rd_valid = mrv_q;
  assign mem_rd_addr  = cur_q;
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               resp_valid,
  input logic [1:0]         resp_src,
  input logic               mem_rd_valid,
  input logic               mem_rsp_valid,
  input logic [ENTRIES-1:0] vb_hit_vec
);
  // R2
  direct_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_src == 2'd0) |-> $past(req_valid && req_ready));

  // R3
  victim_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_src == 2'd1) |-> ($past(!req_ready) && $past(req_valid && req_ready, 2)));

  // R5
  mem_req_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> $past(req_valid && req_ready));

  // R5
  mem_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_src == 2'd2) |-> $past(mem_rsp_valid));

  // R11
  busy_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  // R9
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vb_hit_vec));
endmodule

bind victim_cache vc_checker #(.ENTRIES(VC_ENTRIES)) u_vc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_src(resp_src), .mem_rd_valid(mem_rd_valid),
  .mem_rsp_valid(mem_rsp_valid), .vb_hit_vec(vb_hit_vec)
);

// File: tb/victim_cache_bench.sv
`timescale 1ns/1ps
module victim_cache_bench;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;
  localparam int VC     = 3;
  localparam int SETS   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready, resp_valid, mem_rd_valid;
  logic [DATA_W-1:0] resp_data;
  logic [1:0]        resp_src;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  victim_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .VC_ENTRIES(VC)) u_victim_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_src(resp_src), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int errors = 0;
  int checks = 0;
  int lat = 1;
  int tstamp = 0;
  bit done = 1'b0;

  bit m_dv [SETS];
  int m_dtag [SETS];
  bit v_ok [VC];
  int v_ad [VC];
  int v_st [VC];

  function automatic logic [DATA_W-1:0] line_data(int a);
    return DATA_W'(a * 291 + 23040);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Next level: answers each read after lat cycles (R10).
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        int a;
        a = int'(mem_rd_addr);
        repeat (lat - 1) @(negedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_data(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic access(int a);
    int s, t, kind, way, cnt, exp_lat, r, oldest;
    bit saw_mem, rdy1;
    logic [ADDR_W-1:0] maddr;
    s = a % SETS;
    t = a / SETS;
    way = -1;
    if (m_dv[s] && m_dtag[s] == t) kind = 0;
    else begin
      for (int i = 0; i < VC; i++) if (v_ok[i] && v_ad[i] == a) way = i;
      kind = (way >= 0) ? 1 : 2;
    end
    lat = 1 + (checks % 5);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1;
    saw_mem = mem_rd_valid;
    maddr = mem_rd_addr;
    rdy1 = req_ready;
    while (!resp_valid && cnt < 60) begin
      @(negedge clk);
      cnt++;
    end
    exp_lat = (kind == 0) ? 1 : (kind == 1) ? 2 : lat + 2;
    case (kind)
      0: begin
        chk(resp_src == 2'd0, "R2", "source", int'(resp_src), 0);
        chk(resp_data == line_data(a), "R2", "data", int'(resp_data), int'(line_data(a)));
        chk(cnt == exp_lat, "R2", "latency", cnt, exp_lat);
        chk(!saw_mem, "R2", "no memory read", int'(saw_mem), 0);
        chk(rdy1, "R11", "ready after hit", int'(rdy1), 1);
      end
      1: begin
        chk(resp_src == 2'd1, "R4 R6 R8", "source", int'(resp_src), 1);
        chk(resp_data == line_data(a), "R3", "data", int'(resp_data), int'(line_data(a)));
        chk(cnt == exp_lat, "R3", "latency", cnt, exp_lat);
        chk(!saw_mem, "R3", "no memory read", int'(saw_mem), 0);
        chk(!rdy1, "R11", "busy during swap", int'(rdy1), 0);
      end
      default: begin
        chk(resp_src == 2'd2, "R5 R7 R1", "source", int'(resp_src), 2);
        chk(resp_data == line_data(a), "R5", "data", int'(resp_data), int'(line_data(a)));
        chk(cnt == exp_lat, "R10", "latency", cnt, exp_lat);
        chk(saw_mem && int'(maddr) == a, "R5", "read address", int'(maddr), a);
        chk(!rdy1, "R11", "busy during fetch", int'(rdy1), 0);
      end
    endcase
    // Reference model update by write order.
    if (kind == 1) begin
      v_ok[way] = m_dv[s];
      v_ad[way] = m_dtag[s] * SETS + s;
      v_st[way] = ++tstamp;
      m_dv[s] = 1'b1;
      m_dtag[s] = t;
    end else if (kind == 2) begin
      if (m_dv[s]) begin
        r = -1;
        for (int i = 0; i < VC; i++) if (r < 0 && !v_ok[i]) r = i;
        if (r < 0) begin
          oldest = 0;
          for (int i = 1; i < VC; i++) if (v_st[i] < v_st[oldest]) oldest = i;
          r = oldest;
        end
        v_ok[r] = 1'b1;
        v_ad[r] = m_dtag[s] * SETS + s;
        v_st[r] = ++tstamp;
      end
      m_dv[s] = 1'b1;
      m_dtag[s] = t;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SETS; i++) begin m_dv[i] = 1'b0; m_dtag[i] = 0; end
    for (int i = 0; i < VC; i++) begin v_ok[i] = 1'b0; v_ad[i] = 0; v_st[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state at the ports
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "no response after reset", int'(resp_valid), 0);
    chk(mem_rd_valid == 1'b0, "R1", "no read after reset", int'(mem_rd_valid), 0);

    // Conflict sweep: more tags per set than victim entries, forward then reverse.
    for (int s = 0; s < SETS; s++) begin
      for (int rep = 0; rep < 2; rep++)
        for (int t = 0; t < VC + 2; t++) access(t * SETS + s);
      for (int t = VC + 1; t >= 0; t--) access(t * SETS + s);
      access(s);
      access(s);
    end
    // Interleaved sequence across sets; R9 is watched throughout by the checker.
    for (int i = 0; i < 400; i++) access((i * 5 + (i * i) % 7 + (i / 9) * 3) % 48);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule